// File: doc/BRIEF.md
# Instruction Length and Skip Sequencer

This block drives the program counter of a small 16-bit processor core through one instruction step. On a start request it fetches the word at the current PC and splits it into a 4-bit opcode and two 6-bit operand codes. It works out how many words the instruction occupies and presents the decoded fields to the operand and arithmetic stages for one cycle. It then waits for the execute stage to report completion.

When execution completes, the block picks one of four next-PC outcomes. A plain instruction continues at the word after itself. A subroutine call raises a push request carrying the return address and jumps to the resolved target. A reserved extended opcode acts as a no-op and raises an illegal-instruction flag. A failed conditional makes the block fetch the following word only to measure its length, then jump over it without presenting it downstream.

Operand value resolution, stack pointer arithmetic and the ALU sit outside this block. The block is told the call target and the skip verdict. It never presents a skipped instruction's operand codes, so pop and push codes in that instruction cannot move the stack pointer.

Top module: `ils_sequencer`

## Requirements
- R1: The fetched word is split with the opcode in bits [3:0], operand a in bits [9:4] and operand b in bits [15:10], all held on the decode outputs while `dec_valid` is high.
- R2: Instruction length is 1 plus 1 for each counted operand whose code lies in 0x10..0x17 or equals 0x1e or 0x1f; codes 0x18..0x1d and 0x00..0x0f and 0x20..0x3f add nothing.
- R3: When the opcode is 0, the a field is an extended opcode and only operand b counts toward length.
- R4: For an ordinary instruction, `next_pc` becomes the step's PC plus the instruction length when `step_done` pulses.
- R5: Extended opcode 0x01 is a call. `call_push` pulses together with `step_done`, `push_data` equals PC plus length, and `next_pc` equals `call_target`.
- R6: Any other extended opcode raises `illegal` with `step_done`, gives no push, and continues at PC plus length.
- R7: For opcodes 0xC..0xF, a set `exec_skip` makes the block read the word at PC plus length, and `next_pc` becomes PC plus length plus that instruction's length. The R2/R3 rules apply to the skipped word.
- R8: `exec_skip` has no effect for opcodes 0x0..0xB.
- R9: A skipped instruction never raises `dec_valid` or `call_push`; each step gives exactly one `dec_valid` pulse.
- R10: After reset, `next_pc` is 0 and `dec_valid`, `call_push`, `illegal`, `step_done` and `mem_rd_en` are low.
- R11: `step_start` is ignored while a step is in progress: no memory read and no extra decode is issued.
- R12: `dec_valid` rises on the third clock edge after `step_start` is sampled. `step_done` follows on the edge that samples `exec_done` when no skip happens, and two edges later when a skip happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_start | input | 1 | Begin a step at `pc_in` |
| pc_in | input | 16 | PC of the instruction to run |
| mem_rd_en | output | 1 | Memory read strobe (data expected one cycle later) |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data |
| dec_valid | output | 1 | Decoded fields valid (one-cycle pulse) |
| dec_opcode | output | 4 | Basic opcode |
| dec_opa | output | 6 | Operand a code / extended opcode |
| dec_opb | output | 6 | Operand b code |
| dec_len | output | 2 | Instruction length in words |
| exec_done | input | 1 | Execute stage finished this step |
| exec_skip | input | 1 | Conditional failed, skip next instruction |
| call_target | input | 16 | Resolved operand value for a call |
| call_push | output | 1 | Request to push `push_data` on the stack |
| push_data | output | 16 | Return address for a call |
| illegal | output | 1 | Reserved extended opcode seen |
| step_done | output | 1 | Step finished, `next_pc` valid |
| next_pc | output | 16 | PC for the next step |

## Verification
Decode results are due three edges after `step_start` is sampled. A step's final result is due on the edge that samples `exec_done`, or two edges later when a skip read is needed. The driver counts falling edges after each stimulus and checks that `dec_valid` and `step_done` are low before their due edge and high on it. A scoreboard queue holds the expected length, fields, next PC, push and illegal values. A monitor compares them on the falling edge where `step_done` is high and also counts `dec_valid` pulses per step, which exposes any decode of a skipped word.

// File: rtl/ils_pkg.sv
// Shared widths, instruction layout and sequencer states.
// Assumes a 16-bit word with a 4-bit opcode and two 6-bit operand codes.
package ils_pkg;
    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int OPR_W  = 6;
    localparam int LEN_W  = 2;

    typedef struct packed {
        logic [OPR_W-1:0] opb;
        logic [OPR_W-1:0] opa;
        logic [OPC_W-1:0] opc;
    } instr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DEC, ST_EXEC, ST_SKW, ST_SKD
    } seq_state_t;

    // True when an operand code pulls one extra word from the stream.
    function automatic logic takes_word(input logic [OPR_W-1:0] code);
        return ((code >= 6'h10) && (code <= 6'h17)) || (code == 6'h1e) || (code == 6'h1f);
    endfunction
endpackage

// File: rtl/ils_split.sv
// Field splitter: breaks a raw word into opcode and operand codes.
// Assumes the layout in ils_pkg::instr_t; purely combinational.
module ils_split
    import ils_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic [OPR_W-1:0]  opa,
    output logic [OPR_W-1:0]  opb
);
    instr_t f;

    // Reinterpret the word as the packed field layout.
    always_comb begin
        f   = instr_t'(word);
        opc = f.opc;
        opa = f.opa;
        opb = f.opb;
    end
endmodule

// File: rtl/ils_len.sv
// Length calculator: counts words occupied by one instruction.
// Assumes opcode 0 marks the extended form where operand a is not an operand.
module ils_len
    import ils_pkg::*;
#(
    parameter int N_OPR = 2
) (
    input  logic [OPC_W-1:0]       opc,
    input  logic [N_OPR*OPR_W-1:0] codes,   // operand a in slot 0, b in slot 1
    output logic [LEN_W-1:0]       len
);
    localparam int EXT_SLOT = 0;
    logic [N_OPR-1:0] extra;

    // One word-count bit per operand slot; slot 0 is dropped for the extended form.
    for (genvar i = 0; i < N_OPR; i++) begin : g_opr
        always_comb begin
            extra[i] = takes_word(codes[i*OPR_W +: OPR_W]);
            if (i == EXT_SLOT && opc == '0)
                extra[i] = 1'b0;
        end
    end

    // Base word plus the counted operands.
    always_comb begin
        len = LEN_W'(1);
        for (int k = 0; k < N_OPR; k++)
            len = len + LEN_W'(extra[k]);
    end
endmodule

// File: rtl/ils_sequencer.sv
// Step sequencer: fetches, decodes, sizes and retires one instruction,
// handling calls, reserved extended opcodes and conditional skips.
// Assumes memory returns data one cycle after mem_rd_en, and that the
// execute stage raises exec_done once per step after dec_valid.
module ils_sequencer
    import ils_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CALL_SUB = 1,
    parameter int COND_MIN = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_start,
    input  logic [AW-1:0]      pc_in,
    output logic               mem_rd_en,
    output logic [AW-1:0]      mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               dec_valid,
    output logic [OPC_W-1:0]   dec_opcode,
    output logic [OPR_W-1:0]   dec_opa,
    output logic [OPR_W-1:0]   dec_opb,
    output logic [LEN_W-1:0]   dec_len,
    input  logic               exec_done,
    input  logic               exec_skip,
    input  logic [AW-1:0]      call_target,
    output logic               call_push,
    output logic [AW-1:0]      push_data,
    output logic               illegal,
    output logic               step_done,
    output logic [AW-1:0]      next_pc
);
    seq_state_t       state;
    logic [AW-1:0]    pc_q;
    logic [OPC_W-1:0] rd_opc;
    logic [OPR_W-1:0] rd_opa, rd_opb;
    logic [LEN_W-1:0] rd_len;
    logic [AW-1:0]    after_pc;
    logic             is_ext, is_call, is_cond;

    ils_split u_split (
        .word (mem_rdata),
        .opc  (rd_opc),
        .opa  (rd_opa),
        .opb  (rd_opb)
    );

    ils_len #(.N_OPR(2)) u_len (
        .opc   (rd_opc),
        .codes ({rd_opb, rd_opa}),
        .len   (rd_len)
    );

    // Classify the held instruction and form the address past it.
    always_comb begin
        after_pc = pc_q + AW'(dec_len);
        is_ext   = (dec_opcode == '0);
        is_call  = is_ext && (dec_opa == OPR_W'(CALL_SUB));
        is_cond  = (dec_opcode >= OPC_W'(COND_MIN));
    end

    // Step state machine with pulse outputs cleared each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pc_q       <= '0;
            mem_rd_en  <= 1'b0;
            mem_addr   <= '0;
            dec_valid  <= 1'b0;
            dec_opcode <= '0;
            dec_opa    <= '0;
            dec_opb    <= '0;
            dec_len    <= '0;
            call_push  <= 1'b0;
            push_data  <= '0;
            illegal    <= 1'b0;
            step_done  <= 1'b0;
            next_pc    <= '0;
        end else begin
            mem_rd_en <= 1'b0;
            dec_valid <= 1'b0;
            call_push <= 1'b0;
            illegal   <= 1'b0;
            step_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (step_start) begin
                    pc_q      <= pc_in;
                    mem_rd_en <= 1'b1;
                    mem_addr  <= pc_in;
                    state     <= ST_FETCH;
                end
                ST_FETCH: state <= ST_DEC;
                ST_DEC: begin
                    dec_opcode <= rd_opc;
                    dec_opa    <= rd_opa;
                    dec_opb    <= rd_opb;
                    dec_len    <= rd_len;
                    dec_valid  <= 1'b1;
                    state      <= ST_EXEC;
                end
                ST_EXEC: if (exec_done) begin
                    if (is_call) begin
                        call_push <= 1'b1;
                        push_data <= after_pc;
                        next_pc   <= call_target;
                        step_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (is_ext) begin
                        illegal   <= 1'b1;
                        next_pc   <= after_pc;
                        step_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (is_cond && exec_skip) begin
                        mem_rd_en <= 1'b1;
                        mem_addr  <= after_pc;
                        state     <= ST_SKW;
                    end else begin
                        next_pc   <= after_pc;
                        step_done <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_SKW: state <= ST_SKD;
                ST_SKD: begin
                    next_pc   <= mem_addr + AW'(rd_len);
                    step_done <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_len >= 2'd1 && dec_len <= 2'd3)); // R2
    AST_PUSH_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        call_push |-> (step_done && !illegal)); // R5
    AST_ILLEGAL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (step_done && !call_push)); // R6
    AST_SKIP_NO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKW || state == ST_SKD) |-> (!dec_valid && !call_push)); // R9
    AST_PC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(next_pc) |-> step_done); // R4
    AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_EXEC) |=> !mem_rd_en); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done); // R12
endmodule

// File: tb/ils_sequencer_tb.sv
// Scoreboard bench: the driver queues the expected outcome of each step,
// and the monitor compares it when step_done pulses.
module ils_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_start = 1'b0;
    logic [15:0] pc_in = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        dec_valid;
    logic [3:0]  dec_opcode;
    logic [5:0]  dec_opa, dec_opb;
    logic [1:0]  dec_len;
    logic        exec_done = 1'b0;
    logic        exec_skip = 1'b0;
    logic [15:0] call_target = '0;
    logic        call_push;
    logic [15:0] push_data;
    logic        illegal;
    logic        step_done;
    logic [15:0] next_pc;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [15:0] word;
        logic [1:0]  len;
        logic [15:0] npc;
        logic        push;
        logic [15:0] pdata;
        logic        ill;
    } exp_t;
    exp_t sb[$];

    logic [15:0] mem [0:255];

    always #2 clk = ~clk;

    ils_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .step_start(step_start), .pc_in(pc_in),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_opa(dec_opa),
        .dec_opb(dec_opb), .dec_len(dec_len), .exec_done(exec_done),
        .exec_skip(exec_skip), .call_target(call_target), .call_push(call_push),
        .push_data(push_data), .illegal(illegal), .step_done(step_done),
        .next_pc(next_pc)
    );

    // Registered memory model: one cycle read latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: collects decode fields and scores each retired step.
    logic [15:0] seen_word;
    logic [1:0]  seen_len;
    int          dec_count = 0;
    always @(negedge clk) begin
        if (dec_valid) begin
            seen_word = {dec_opb, dec_opa, dec_opcode};
            seen_len  = dec_len;
            dec_count++;
        end
        if (step_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4 unexpected step_done", 32'(next_pc), 32'hffff);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(seen_word == e.word, "R1 fields", 32'(seen_word), 32'(e.word));
                check(seen_len == e.len, "R2/R3 length", 32'(seen_len), 32'(e.len));
                check(next_pc == e.npc, "R4/R7 next_pc", 32'(next_pc), 32'(e.npc));
                check(call_push == e.push, "R5/R9 call_push", 32'(call_push), 32'(e.push));
                if (e.push)
                    check(push_data == e.pdata, "R5 push_data", 32'(push_data), 32'(e.pdata));
                check(illegal == e.ill, "R6 illegal", 32'(illegal), 32'(e.ill));
                check(dec_count == 1, "R9 one decode per step", 32'(dec_count), 32'd1);
            end
            dec_count = 0;
        end
    end

    // Driver: one step with latency checks; poke tests R11.
    task automatic run(input logic [15:0] pc, input logic [1:0] len, input logic [15:0] npc,
                       input logic push, input logic ill, input logic skip,
                       input logic [15:0] tgt, input int done_lat, input bit poke);
        exp_t e;
        e.word = mem[pc[7:0]]; e.len = len; e.npc = npc;
        e.push = push; e.pdata = pc + 16'(len); e.ill = ill;
        sb.push_back(e);
        @(negedge clk);
        pc_in = pc; step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        if (poke) begin
            pc_in = pc + 16'h0008; step_start = 1'b1;
        end
        check(dec_valid == 1'b0, "R12 decode early", 32'(dec_valid), 32'd0);
        @(negedge clk);
        step_start = 1'b0;
        if (poke) check(mem_rd_en == 1'b0, "R11 busy read", 32'(mem_rd_en), 32'd0);
        check(dec_valid == 1'b0, "R12 decode early", 32'(dec_valid), 32'd0);
        @(negedge clk);
        check(dec_valid == 1'b1, "R12 decode due", 32'(dec_valid), 32'd1);
        exec_done = 1'b1; exec_skip = skip; call_target = tgt;
        for (int i = 1; i <= done_lat; i++) begin
            @(negedge clk);
            exec_done = 1'b0; exec_skip = 1'b0;
            check(step_done == (i == done_lat), "R12 done timing", 32'(step_done), 32'(i == done_lat));
        end
        @(negedge clk);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h10] = 16'h0401; // basic op1, a=0 b=1
        mem[8'h20] = 16'h7D02; // a=0x10 b=0x1f
        mem[8'h30] = 16'h81E3; // a=0x1e b=0x20
        mem[8'h38] = 16'h5D84; // a=0x18 b=0x17
        mem[8'h40] = 16'h7C10; // call, b=0x1f
        mem[8'h50] = 16'h0010; // call, b=0
        mem[8'h60] = 16'h85F0; // ext 0x1f, b=0x21
        mem[8'h70] = 16'h4000; // ext 0, b=0x10
        mem[8'h80] = 16'h7C0C; // cond 0xC, b=0x1f
        mem[8'h82] = 16'h7D02; // skipped, len3
        mem[8'h90] = 16'h000F; // cond 0xF
        mem[8'h91] = 16'h6810; // skipped call with push code
        mem[8'hA0] = 16'h000D; // cond, not skipped
        mem[8'hB0] = 16'h0401; // basic with skip flag set
        mem[8'hC0] = 16'h000E; // cond 0xE
        mem[8'hC1] = 16'h79F0; // skipped ext, a=0x1f b=0x1e, len2
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(next_pc == 16'h0 && !dec_valid && !call_push && !illegal && !step_done && !mem_rd_en,
              "R10 reset", 32'({next_pc, dec_valid, call_push, illegal, step_done, mem_rd_en}), 32'h0);
        run(16'h10, 2'd1, 16'h0011, 0, 0, 0, 16'h0, 1, 0); // R4 R2
        run(16'h20, 2'd3, 16'h0023, 0, 0, 0, 16'h0, 1, 0); // R2 both counted
        run(16'h30, 2'd2, 16'h0032, 0, 0, 0, 16'h0, 1, 1); // R2 R11
        run(16'h38, 2'd2, 16'h003A, 0, 0, 0, 16'h0, 1, 0); // R2 code 0x18 not counted
        run(16'h40, 2'd2, 16'h1234, 1, 0, 0, 16'h1234, 1, 0); // R5 R3
        run(16'h50, 2'd1, 16'h0077, 1, 0, 0, 16'h0077, 1, 0); // R5
        run(16'h60, 2'd1, 16'h0061, 0, 1, 0, 16'h0, 1, 0); // R6 R3 a not counted
        run(16'h70, 2'd2, 16'h0072, 0, 1, 0, 16'h0, 1, 0); // R6
        run(16'h80, 2'd2, 16'h0085, 0, 0, 1, 16'h0, 3, 0); // R7
        run(16'h90, 2'd1, 16'h0092, 0, 0, 1, 16'h0, 3, 0); // R7 R9
        run(16'hA0, 2'd1, 16'h00A1, 0, 0, 0, 16'h0, 1, 0); // R7 pass
        run(16'hB0, 2'd1, 16'h00B1, 0, 0, 1, 16'h0, 1, 0); // R8
        run(16'hC0, 2'd1, 16'h00C3, 0, 0, 1, 16'h0, 3, 0); // R7 R3 skipped ext
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4 all steps retired", 32'(sb.size()), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule